// File: doc/BRIEF.md
# Flash Status and Error-Lockout Controller

This block is the status-register and command-gating logic of a serial NOR flash slave. A command front end presents one decoded opcode per cycle. The controller decides whether to accept it, reject it or ignore it. It owns four status bits: the busy flag, the write-enable latch, the program-fault flag and the erase-fault flag. It also starts a stub embedded-operation engine for program and erase commands. The engine runs for a fixed number of cycles and then reports success or failure, as chosen by a test input that is sampled when the operation starts.

If a program or erase fails, the device stays busy and enters a lockout. During the lockout only a small recovery set of commands gets through. The normal way back to standby is a clear-status command and then a write-disable command. A software reset command, or the hardware reset pin, returns the device to standby directly.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, `status1` and `status2` read 0x00 and neither `cmd_accept` nor `cmd_reject` is high.
- R2: Opcode 0x06 sets the write-enable latch, which is `status1` bit 1. Opcode 0x04 clears it. Each accepted command raises `cmd_accept` for one cycle, one cycle after the command is presented, together with the status update.
- R3: Program (0x02) or erase (0xD8) presented while the write-enable latch is 0 raises `cmd_reject` and leaves the status unchanged.
- R4: An accepted program or erase sets `status1` bit 0 (busy). It also shows the running kind on `status2`: bit 0 for program, bit 1 for erase. The run lasts OP_CYCLES cycles. On success, busy, the latch and `status2` all return to 0.
- R5: A failed program sets `status1` bit 6 and a failed erase sets bit 5. While either bit is 1, busy stays at 1.
- R6: While a fault bit is set, only 0x30, 0x04, 0x05, 0x07 and 0xF0 are accepted. Every other value, including unknown ones, is rejected and has no effect.
- R7: Clear-status (0x30) clears busy and both fault bits. A following write-disable (0x04) clears the latch, which returns `status1` to 0x00.
- R8: Software reset (0xF0) is accepted in every state. It clears all status bits and aborts any running operation. If it arrives in the same cycle as a completion, the reset wins.
- R9: While an operation runs without a fault, 0x05, 0x07 and 0xF0 are accepted. The other known opcodes are rejected and unknown values are ignored.
- R10: Outside a lockout and outside a run, an unknown opcode raises neither flag and changes nothing.
- R11: A command presented in the cycle in which an operation completes is judged on the state before the completion. The completion takes effect in that same cycle.
- R12: Driving `rst_n` low clears the status outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 8 | Opcode of the command |
| fail_sel | input | 1 | Stub engine: when high at start, the started operation fails |
| status1 | output | 8 | Status byte 1: bit0 busy, bit1 write latch, bit5 erase fault, bit6 program fault |
| status2 | output | 8 | Status byte 2: bit0 program running, bit1 erase running |
| cmd_accept | output | 1 | One-cycle pulse: previous command accepted |
| cmd_reject | output | 1 | One-cycle pulse: previous command rejected |

## Verification
A command can land in the same cycle as the engine's completion, and the two update the same status bits. The bench provokes this by counting cycles from an accepted program and placing a write-enable exactly on the completion cycle. It also places a software reset on the completion cycle of a failing erase. A behavioural model applies the verdict from the state before the edge, then the completion, then the command's effect. The design is compared against this model every cycle, so a wrong precedence shows up either as a wrong accept/reject flag or as a fault bit that should not be there.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int NUM_CMDS = 8;

  localparam int IDX_WREN  = 0;
  localparam int IDX_WRDI  = 1;
  localparam int IDX_CLSR  = 2;
  localparam int IDX_RDS1  = 3;
  localparam int IDX_RDS2  = 4;
  localparam int IDX_SRST  = 5;
  localparam int IDX_PROG  = 6;
  localparam int IDX_ERASE = 7;

  // Opcode for each command index (index order matches the IDX_* constants).
  localparam logic [7:0] CMD_CODES [NUM_CMDS] = '{
    8'h06, 8'h04, 8'h30, 8'h05, 8'h07, 8'hF0, 8'h02, 8'hD8
  };

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PROG  = 2'd1,
    KIND_ERASE = 2'd2
  } op_kind_t;

  typedef struct packed {
    logic     set_wel;
    logic     clr_wel;
    logic     clr_err;
    logic     srst;
    logic     start;
    op_kind_t kind;
  } action_t;

endpackage

// File: rtl/fsc_decode.sv
module fsc_decode
  import fsc_pkg::*;
(
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_op,
  output logic [NUM_CMDS-1:0] hit
);

  // One comparator per known command.
  for (genvar g = 0; g < NUM_CMDS; g++) begin : g_match
    assign hit[g] = cmd_valid && (cmd_op == CMD_CODES[g]);
  end

endmodule

// File: rtl/fsc_gate.sv
module fsc_gate
  import fsc_pkg::*;
(
  input  logic                cmd_valid,
  input  logic [NUM_CMDS-1:0] hit,
  input  logic                locked,
  input  logic                running,
  input  logic                wel,
  output logic                accept,
  output logic                reject,
  output action_t             act
);

  logic known;
  logic recovery_cmd;
  logic read_cmd;
  logic array_cmd;

  always_comb begin
    known        = |hit;
    read_cmd     = hit[IDX_RDS1] | hit[IDX_RDS2];
    recovery_cmd = hit[IDX_CLSR] | hit[IDX_WRDI] | read_cmd;
    array_cmd    = hit[IDX_PROG] | hit[IDX_ERASE];
  end

  always_comb begin
    accept = 1'b0;
    reject = 1'b0;
    act    = '0;
    if (cmd_valid) begin
      if (hit[IDX_SRST]) begin
        accept = 1'b1;
      end else if (locked) begin
        if (recovery_cmd) accept = 1'b1;
        else              reject = 1'b1;
      end else if (running) begin
        if (read_cmd)   accept = 1'b1;
        else if (known) reject = 1'b1;
      end else if (array_cmd) begin
        if (wel) accept = 1'b1;
        else     reject = 1'b1;
      end else if (known) begin
        accept = 1'b1;
      end

      if (accept) begin
        act.srst    = hit[IDX_SRST];
        act.set_wel = hit[IDX_WREN];
        act.clr_wel = hit[IDX_WRDI];
        act.clr_err = hit[IDX_CLSR];
        act.start   = array_cmd;
        if (hit[IDX_PROG])       act.kind = KIND_PROG;
        else if (hit[IDX_ERASE]) act.kind = KIND_ERASE;
        else                     act.kind = KIND_NONE;
      end
    end
  end

endmodule

// File: rtl/fsc_engine.sv
module fsc_engine
  import fsc_pkg::*;
#(
  parameter int OP_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_t start_kind,
  input  logic     fail_in,
  input  logic     abort,
  output logic     active,
  output op_kind_t kind,
  output logic     done,
  output logic     failed
);

  localparam int CNT_W = $clog2(OP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             active_q, active_d;
  op_kind_t         kind_q, kind_d;
  logic             fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = active_q && (cnt_q == CNT_LAST);

  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    fail_d   = fail_q;
    cnt_d    = cnt_q;
    if (abort) begin
      active_d = 1'b0;
      kind_d   = KIND_NONE;
      fail_d   = 1'b0;
      cnt_d    = '0;
    end else if (start) begin
      active_d = 1'b1;
      kind_d   = start_kind;
      fail_d   = fail_in;
      cnt_d    = CNT_LOAD;
    end else if (at_end) begin
      active_d = 1'b0;
      kind_d   = KIND_NONE;
      fail_d   = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d    = cnt_q - CNT_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= KIND_NONE;
      fail_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      kind_q   <= kind_d;
      fail_q   <= fail_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active = active_q;
  assign kind   = kind_q;
  assign done   = at_end && !abort;
  assign failed = done && fail_q;

endmodule

// File: rtl/fsc_status.sv
module fsc_status
  import fsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  action_t  act,
  input  logic     done,
  input  logic     failed,
  input  op_kind_t done_kind,
  output logic     wip,
  output logic     wel,
  output logic     perr,
  output logic     eerr
);

  logic wip_q, wip_d;
  logic wel_q, wel_d;
  logic perr_q, perr_d;
  logic eerr_q, eerr_d;
  logic upd_en;

  // Clock enable: registers move only when something acts on them.
  assign upd_en = act.srst | act.start | act.set_wel | act.clr_wel | act.clr_err | done;

  always_comb begin
    wip_d  = wip_q;
    wel_d  = wel_q;
    perr_d = perr_q;
    eerr_d = eerr_q;
    if (act.srst) begin
      wip_d  = 1'b0;
      wel_d  = 1'b0;
      perr_d = 1'b0;
      eerr_d = 1'b0;
    end else begin
      if (done) begin
        if (failed) begin
          if (done_kind == KIND_PROG)  perr_d = 1'b1;
          if (done_kind == KIND_ERASE) eerr_d = 1'b1;
        end else begin
          wip_d = 1'b0;
          wel_d = 1'b0;
        end
      end
      if (act.start)   wip_d = 1'b1;
      if (act.clr_err) begin
        wip_d  = 1'b0;
        perr_d = 1'b0;
        eerr_d = 1'b0;
      end
      if (act.set_wel) wel_d = 1'b1;
      if (act.clr_wel) wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q  <= 1'b0;
      wel_q  <= 1'b0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else if (upd_en) begin
      wip_q  <= wip_d;
      wel_q  <= wel_d;
      perr_q <= perr_d;
      eerr_q <= eerr_d;
    end
  end

  assign wip  = wip_q;
  assign wel  = wel_q;
  assign perr = perr_q;
  assign eerr = eerr_q;

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int OP_CYCLES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  input  logic       fail_sel,
  output logic [7:0] status1,
  output logic [7:0] status2,
  output logic       cmd_accept,
  output logic       cmd_reject
);

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   core_rst_n;

  assign sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[SYNC_STAGES-1];

  logic [NUM_CMDS-1:0] hit;
  logic                acc_c, rej_c;
  action_t             act;
  logic                eng_active, eng_done, eng_failed;
  op_kind_t            eng_kind;
  logic                wip, wel, perr, eerr;
  logic                locked;

  assign locked = perr | eerr;

  fsc_decode i_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .hit       (hit)
  );

  fsc_gate i_gate (
    .cmd_valid (cmd_valid),
    .hit       (hit),
    .locked    (locked),
    .running   (eng_active),
    .wel       (wel),
    .accept    (acc_c),
    .reject    (rej_c),
    .act       (act)
  );

  fsc_engine #(.OP_CYCLES(OP_CYCLES)) i_engine (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start      (act.start),
    .start_kind (act.kind),
    .fail_in    (fail_sel),
    .abort      (act.srst),
    .active     (eng_active),
    .kind       (eng_kind),
    .done       (eng_done),
    .failed     (eng_failed)
  );

  fsc_status i_status (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .act       (act),
    .done      (eng_done),
    .failed    (eng_failed),
    .done_kind (eng_kind),
    .wip       (wip),
    .wel       (wel),
    .perr      (perr),
    .eerr      (eerr)
  );

  // Verdict pulses, registered so they line up with the status update.
  logic acc_q, acc_d, rej_q, rej_d;

  always_comb begin
    acc_d = acc_c;
    rej_d = rej_c;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rej_q <= rej_d;
    end
  end

  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign status1    = {1'b0, perr, eerr, 3'b000, wel, wip};
  assign status2    = {6'b0, eng_kind == KIND_ERASE, eng_kind == KIND_PROG};

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status1,
  input logic [7:0] status2,
  input logic       cmd_accept,
  input logic       cmd_reject
);

  p_busy_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status1[6] || status1[5]) |-> status1[0]);

  p_verdict_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));

  p_lock_reject_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject && $past(status1[6] || status1[5])) |-> $stable(status1));

  p_lock_engine_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status1[6] || status1[5]) |-> (status2[1:0] == 2'b00));

  p_run_shows_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status2[1:0] != 2'b00) |-> status1[0]);

  p_single_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status2[1:0]));

endmodule

bind flash_status_ctrl fsc_checker i_fsc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .status1    (status1),
  .status2    (status2),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject)
);

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;

  localparam int OPC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic       fail_sel = 1'b0;
  logic [7:0] status1, status2;
  logic       cmd_accept, cmd_reject;

  always #5 clk = ~clk;

  flash_status_ctrl #(.OP_CYCLES(OPC)) i_flash_status_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .fail_sel   (fail_sel),
    .status1    (status1),
    .status2    (status2),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  // Behavioural reference model.
  bit m_wip, m_wel, m_perr, m_eerr, m_fail, m_acc, m_rej;
  int m_run, m_cnt, m_sync, m_v;

  function automatic int judge(input logic [7:0] op);
    bit lock  = m_perr || m_eerr;
    bit known = op inside {8'h06, 8'h04, 8'h30, 8'h05, 8'h07, 8'hF0, 8'h02, 8'hD8};
    if (op == 8'hF0) return 1;
    if (lock) return (op inside {8'h30, 8'h04, 8'h05, 8'h07}) ? 1 : 2;
    if (m_run != 0) return (op inside {8'h05, 8'h07}) ? 1 : (known ? 2 : 0);
    if (op inside {8'h02, 8'hD8}) return m_wel ? 1 : 2;
    return known ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wip = 0; m_wel = 0; m_perr = 0; m_eerr = 0; m_fail = 0;
      m_acc = 0; m_rej = 0; m_run = 0; m_cnt = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      m_v   = cmd_valid ? judge(cmd_op) : 0;
      m_acc = (m_v == 1);
      m_rej = (m_v == 2);
      if (m_run != 0) begin
        if (m_cnt == 1) begin
          if (m_fail) begin
            if (m_run == 1) m_perr = 1; else m_eerr = 1;
          end else begin
            m_wip = 0; m_wel = 0;
          end
          m_run = 0;
        end else begin
          m_cnt--;
        end
      end
      if (m_v == 1) begin
        case (cmd_op)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'h30: begin m_wip = 0; m_perr = 0; m_eerr = 0; end
          8'hF0: begin m_wip = 0; m_wel = 0; m_perr = 0; m_eerr = 0; m_run = 0; end
          8'h02: begin m_wip = 1; m_run = 1; m_cnt = OPC; m_fail = fail_sel; end
          8'hD8: begin m_wip = 1; m_run = 2; m_cnt = OPC; m_fail = fail_sel; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "model status1", status1, {1'b0, m_perr, m_eerr, 3'b000, m_wel, m_wip});
      check(cur_req, "model status2", status2, {6'b0, m_run == 2, m_run == 1});
      check(cur_req, "model accept", {7'b0, cmd_accept}, {7'b0, m_acc});
      check(cur_req, "model reject", {7'b0, cmd_reject}, {7'b0, m_rej});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Called at a negedge; returns at the next negedge, where the verdict is visible.
  task automatic issue(input logic [7:0] op);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    cur_req = "R1";
    check("R1", "status1", status1, 8'h00);
    check("R1", "status2", status2, 8'h00);
    check("R1", "accept", {7'b0, cmd_accept}, 8'h00);
    check("R1", "reject", {7'b0, cmd_reject}, 8'h00);

    cur_req = "R10";
    issue(8'h99);
    check("R10", "accept", {7'b0, cmd_accept}, 8'h00);
    check("R10", "reject", {7'b0, cmd_reject}, 8'h00);
    check("R10", "status1", status1, 8'h00);

    cur_req = "R3";
    issue(8'h02);
    check("R3", "reject prog", {7'b0, cmd_reject}, 8'h01);
    check("R3", "status1", status1, 8'h00);
    issue(8'hD8);
    check("R3", "reject erase", {7'b0, cmd_reject}, 8'h01);

    cur_req = "R2";
    issue(8'h06);
    check("R2", "accept", {7'b0, cmd_accept}, 8'h01);
    check("R2", "wel set", status1, 8'h02);
    issue(8'h04);
    check("R2", "wel clr", status1, 8'h00);

    cur_req = "R4";
    issue(8'h06);
    fail_sel = 1'b0;
    issue(8'h02);
    check("R4", "accept", {7'b0, cmd_accept}, 8'h01);
    check("R4", "busy", status1, 8'h03);
    check("R4", "prog running", status2, 8'h01);
    idle(OPC + 1);
    check("R4", "done status1", status1, 8'h00);
    check("R4", "done status2", status2, 8'h00);

    cur_req = "R9";
    issue(8'h06);
    issue(8'hD8);
    check("R9", "erase running", status2, 8'h02);
    issue(8'h04);
    check("R9", "wrdi rejected", {7'b0, cmd_reject}, 8'h01);
    check("R9", "wel kept", status1, 8'h03);
    issue(8'h07);
    check("R9", "rds2 accepted", {7'b0, cmd_accept}, 8'h01);
    idle(OPC + 2);
    check("R9", "after run", status1, 8'h00);

    cur_req = "R5";
    issue(8'h06);
    fail_sel = 1'b1;
    issue(8'hD8);
    fail_sel = 1'b0;
    idle(OPC + 1);
    check("R5", "erase fault", status1, 8'h23);
    check("R5", "engine idle", status2, 8'h00);

    cur_req = "R6";
    issue(8'h06);
    check("R6", "wren rejected", {7'b0, cmd_reject}, 8'h01);
    issue(8'h02);
    check("R6", "prog rejected", {7'b0, cmd_reject}, 8'h01);
    check("R6", "status frozen", status1, 8'h23);
    issue(8'h99);
    check("R6", "unknown rejected", {7'b0, cmd_reject}, 8'h01);
    issue(8'h05);
    check("R6", "rds1 accepted", {7'b0, cmd_accept}, 8'h01);

    cur_req = "R7";
    issue(8'h30);
    check("R7", "after clear", status1, 8'h02);
    issue(8'h04);
    check("R7", "standby", status1, 8'h00);

    cur_req = "R5";
    issue(8'h06);
    fail_sel = 1'b1;
    issue(8'h02);
    fail_sel = 1'b0;
    idle(OPC + 1);
    check("R5", "prog fault", status1, 8'h43);

    cur_req = "R8";
    issue(8'hF0);
    check("R8", "srst accepted", {7'b0, cmd_accept}, 8'h01);
    check("R8", "srst clears", status1, 8'h00);

    cur_req = "R11";
    issue(8'h06);
    issue(8'h02);
    idle(OPC - 1);
    issue(8'h06);
    check("R11", "wren on done rejected", {7'b0, cmd_reject}, 8'h01);
    check("R11", "completion applied", status1, 8'h00);

    cur_req = "R8";
    issue(8'h06);
    fail_sel = 1'b1;
    issue(8'hD8);
    fail_sel = 1'b0;
    idle(OPC - 1);
    issue(8'hF0);
    check("R8", "srst beats fault", status1, 8'h00);
    idle(2);
    check("R8", "still clear", status1, 8'h00);

    cur_req = "R12";
    issue(8'h06);
    check("R12", "wel before reset", status1, 8'h02);
    cmp_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12", "async clear", status1, 8'h00);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    check("R12", "after release", status1, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule